// File: doc/BRIEF.md
# Run-time configurable two-wire register slave

This block is a target-only device on a two-wire serial bus (I2C-style signalling). It answers a 7-bit slave address and gives a host read and write access to a bank of eight small configuration registers. Every transfer carries a full byte, but each register stores only a 4-bit value. The block never drives SCL and never starts a transfer. It pulls SDA low only to acknowledge a byte or to send a 0 data bit.

The slave address has two parts. The upper four bits are a device-type code and the lower three bits match the `pin_addr` strap inputs. The last register of the bank is the control register. Its bit 3 picks which of two device-type codes the slave answers. Its bit 0 decides whether the strap bits must match or are treated as a wildcard. Its bits 2:1 set the access rights. A new value written to the control register is adopted only at the next stop condition, so the transfer in progress finishes under the old settings.

A write is the address byte with R/W=0, then a word-pointer byte, then any number of data bytes. A read is a repeated start followed by the address byte with R/W=1. Reads begin at the current word pointer. The pointer advances after every data byte, in both directions, and wraps from 7 back to 0.

Top module: `cfg_i2c_slave`

## Requirements
- R1: An SDA fall while SCL is high is a start condition and restarts address reception in any state. An SDA rise while SCL is high is a stop condition: it returns the slave to idle and SDA is released on the next clock.
- R2: The device-type field (address bits 7:4) must equal 4'b1011 when control bit 3 is 1, or 4'b1010 when it is 0. Any other code is not acknowledged.
- R3: When control bit 0 is 1, address bits 3:1 must equal `pin_addr`. When it is 0, any value in those bits is accepted.
- R4: In a write, the byte after the address is the word pointer; its low three bits are used. Each following data byte is stored at the pointer, acknowledged, and the pointer steps by one, wrapping from 7 to 0.
- R5: Only bits 3:0 of a written data byte are stored. Bits 7:4 are discarded and always read back as zero.
- R6: After a repeated start with R/W=1, the slave sends the register at the current pointer, most significant bit first, and advances the pointer after each byte. It keeps sending while the host acknowledges. After a host NACK it releases SDA and waits for a start or stop.
- R7: Access mode 2'b00 (control bits 2:1) denies all access. The slave acknowledges no address at all, for either direction.
- R8: Access mode 2'b01 is read-only. Read addresses are acknowledged. Write addresses are not, and the bytes that follow them leave the register bank unchanged.
- R9: Access modes 2'b10 and 2'b11 allow reads and writes. A value written to the control register (word 7) takes effect at the next stop condition, not earlier. A repeated start in the same transfer is still decoded under the old settings.
- R10: SDA is only ever pulled low (open-drain), and the pull-down changes only while SCL is low.
- R11: After reset, words 0 to 6 hold zero and the control register holds 4'b1111: code 4'b1011, read/write, strap bits must match. SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| pin_addr | input | 3 | Strap value for the low address bits |
| sda_drive_low | output | 1 | When 1, the pad pulls SDA low; otherwise SDA is released |
| cfg_regs | output | 32 | Stored register contents; word k occupies bits 4k+3:4k |

## Verification
The checks assume a bus that is slow compared with `clk`. Each SCL level lasts many clock cycles, and SDA moves only while SCL is low, except when the host deliberately makes a start or stop. The checks also assume the host never makes a stop while the slave is pulling SDA low. The bench host bit-bangs the bus with quarter-periods of eight clock cycles. It changes SDA one quarter after an SCL fall, which is well after the two-stage synchronizer and edge detector have seen that fall. It makes stops only after the slave has released the line.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_PTR,
    K_DATA
  } rx_kind_t;

  // control word layout: order of fields fixes bit positions 3..0
  typedef struct packed {
    logic       code_hi;    // 1: type code 4'b1011, 0: 4'b1010
    logic [1:0] mode;       // 00 denied, 01 read only, 1x read/write
    logic       pin_exact;  // 1: strap bits must match
  } ctrl_t;

  localparam logic [3:0] TYPE_CODE_HI = 4'b1011;
  localparam logic [3:0] TYPE_CODE_LO = 4'b1010;

  function automatic logic mode_can_read(input logic [1:0] m);
    return m != 2'b00;
  endfunction

  function automatic logic mode_can_write(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_p, sda_p;
  logic              scl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[LAST];
      sda_p  <= sda_sh[LAST];
    end
  end

  assign scl_s     = scl_sh[LAST];
  assign sda_q     = sda_sh[LAST];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int          NREG     = 8,
  parameter int          DW       = 4,
  parameter logic [3:0]  CTRL_RST = 4'b1111,
  localparam int         AW       = $clog2(NREG),
  localparam int         CTRL_IDX = NREG - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  input  logic               commit,
  output logic [3:0]         active_ctrl,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    localparam logic [DW-1:0] RST_V = (g == CTRL_IDX) ? DW'(CTRL_RST) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)                          mem[g] <= RST_V;
      else if (we && waddr == AW'(g))      mem[g] <= wdata;
    end
    assign flat[g*DW +: DW] = mem[g];
  end

  // control settings are adopted only at a stop condition
  always_ff @(posedge clk) begin
    if (!rst_n)      active_ctrl <= CTRL_RST;
    else if (commit) active_ctrl <= mem[CTRL_IDX][3:0];
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import cfg_i2c_pkg::*;
#(
  parameter  int NREG   = 8,
  parameter  int DW     = 4,
  localparam int AW     = $clog2(NREG),
  localparam int BYTE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [2:0]    pin_addr,
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          drive_low
);
  bus_state_t        state;
  rx_kind_t          kind;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              to_tx;
  logic              dev_hit;
  logic [BYTE_W-1:0] rd_byte;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(NREG - 1)) ? '0 : p + AW'(1);
  endfunction

  assign rd_byte = {{(BYTE_W-DW){1'b0}}, rd_data};
  assign dev_hit = (sh[7:4] == (ctrl.code_hi ? TYPE_CODE_HI : TYPE_CODE_LO)) &&
                   (!ctrl.pin_exact || sh[3:1] == pin_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= K_DEV;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      to_tx     <= 1'b0;
      ptr       <= '0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
      drive_low <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        state     <= ST_RX;
        kind      <= K_DEV;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        drive_low <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[BYTE_W-2:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              unique case (kind)
                K_DEV: begin
                  if (dev_hit && sh[0] && mode_can_read(ctrl.mode)) begin
                    drive_low <= 1'b1;
                    to_tx     <= 1'b1;
                    state     <= ST_ACK;
                  end else if (dev_hit && !sh[0] && mode_can_write(ctrl.mode)) begin
                    drive_low <= 1'b1;
                    to_tx     <= 1'b0;
                    kind      <= K_PTR;
                    state     <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  ptr       <= sh[AW-1:0];
                  drive_low <= 1'b1;
                  to_tx     <= 1'b0;
                  kind      <= K_DATA;
                  state     <= ST_ACK;
                end
                default: begin
                  we        <= 1'b1;
                  waddr     <= ptr;
                  wdata     <= sh[DW-1:0];
                  ptr       <= bump(ptr);
                  drive_low <= 1'b1;
                  to_tx     <= 1'b0;
                  state     <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (to_tx) begin
                tx        <= rd_byte;
                drive_low <= ~rd_byte[BYTE_W-1];
                state     <= ST_TX;
              end else begin
                drive_low <= 1'b0;
                state     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                drive_low <= 1'b0;
                ptr       <= bump(ptr);
                state     <= ST_MACK;
              end else begin
                tx        <= {tx[BYTE_W-2:0], 1'b0};
                drive_low <= ~tx[BYTE_W-2];
                cnt       <= cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise && sda_q) begin
              state <= ST_IDLE;
            end else if (scl_fall) begin
              tx        <= rd_byte;
              drive_low <= ~rd_byte[BYTE_W-1];
              cnt       <= '0;
              state     <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter  int NREG        = 8,
  parameter  int REG_W       = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [2:0]            pin_addr,
  output logic                  sda_drive_low,
  output logic [NREG*REG_W-1:0] cfg_regs
);
  logic             sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic             reg_we;
  logic [AW-1:0]    reg_waddr, ptr;
  logic [REG_W-1:0] reg_wdata, reg_rdata;
  logic [3:0]       active_ctrl;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_fsm #(.NREG(NREG), .DW(REG_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .pin_addr  (pin_addr),
    .ctrl      (ctrl_t'(active_ctrl)),
    .rd_data   (reg_rdata),
    .ptr       (ptr),
    .we        (reg_we),
    .waddr     (reg_waddr),
    .wdata     (reg_wdata),
    .drive_low (sda_drive_low)
  );

  cfg_reg_bank #(.NREG(NREG), .DW(REG_W), .CTRL_RST(4'b1111)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (reg_we),
    .waddr       (reg_waddr),
    .wdata       (reg_wdata),
    .raddr       (ptr),
    .rdata       (reg_rdata),
    .commit      (stop_det),
    .active_ctrl (active_ctrl),
    .flat        (cfg_regs)
  );

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_drive_low,
  input logic       stop_det,
  input logic [3:0] active_ctrl,
  input logic       reg_we
);

  assert_release_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low);

  assert_denied_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_ctrl[2:1] == 2'b00) |-> !sda_drive_low);

  assert_readonly_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_ctrl[2:1] == 2'b01) |-> !reg_we);

  assert_ctrl_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_ctrl) |-> $past(stop_det));

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_i);

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_i         (scl_i),
  .sda_drive_low (sda_drive_low),
  .stop_det      (stop_det),
  .active_ctrl   (active_ctrl),
  .reg_we        (reg_we)
);

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [2:0]  pin_addr = 3'b101;
  logic        sda_drive_low;
  logic [31:0] cfg_regs;
  logic        bus_sda;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  assign bus_sda = m_sda & ~sda_drive_low;

  always #4 clk = ~clk;

  cfg_i2c_slave dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl),
    .sda_i         (bus_sda),
    .pin_addr      (pin_addr),
    .sda_drive_low (sda_drive_low),
    .cfg_regs      (cfg_regs)
  );

  // {req, op (1 write, 2 read), word, data/expected}
  localparam logic [19:0] VEC [0:7] = '{
    {4'd4,  4'd1, 4'd0, 8'h05},
    {4'd5,  4'd1, 4'd3, 8'hFA},
    {4'd4,  4'd2, 4'd0, 8'h05},
    {4'd5,  4'd2, 4'd3, 8'h0A},
    {4'd4,  4'd1, 4'd6, 8'h3C},
    {4'd5,  4'd2, 4'd6, 8'h0C},
    {4'd11, 4'd2, 4'd1, 8'h00},
    {4'd11, 4'd2, 4'd7, 8'h0F}
  };

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(Q);
      m_scl = 1'b1; hold(2 * Q);
      m_scl = 1'b0; hold(Q);
    end
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    ack = !bus_sda; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic recv(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      m_scl = 1'b1; hold(Q);
      b[i] = bus_sda; hold(Q);
      m_scl = 1'b0; hold(Q);
    end
    m_sda = nack; hold(Q);
    m_scl = 1'b1; hold(2 * Q);
    m_scl = 1'b0; hold(Q);
    m_sda = 1'b1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    hold(5);
    rst_n = 1'b1;
    hold(5);
  endtask

  task automatic wr_word(input string req, input logic [7:0] dev, input logic [7:0] w,
                         input logic [7:0] d);
    logic a;
    bus_start;
    send(dev, a);     chk(req, a, 1);
    send(w, a);       chk(req, a, 1);
    send(d, a);       chk(req, a, 1);
    bus_stop;
  endtask

  task automatic rd_word(input string req, input logic [7:0] dev, input logic [7:0] w,
                         input logic [7:0] exp);
    logic a;
    logic [7:0] b;
    bus_start;
    send(dev, a);        chk(req, a, 1);
    send(w, a);          chk(req, a, 1);
    bus_start;
    send(dev | 8'h01, a); chk(req, a, 1);
    recv(1'b1, b);       chk(req, b, exp);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    do_reset;
    // R11: reset state
    chk("R11", sda_drive_low, 0);
    chk("R11", cfg_regs, 32'hF000_0000);

    // vector table: single writes and reads under default settings (code 1011, pins 101)
    for (int v = 0; v < 8; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v][19:16]);
      if (VEC[v][15:12] == 4'd1)
        wr_word(tag, 8'hBA, {4'h0, VEC[v][11:8]}, VEC[v][7:0]);
      else
        rd_word(tag, 8'hBA, {4'h0, VEC[v][11:8]}, VEC[v][7:0]);
    end
    chk("R5", cfg_regs, 32'hFC00_A005);

    // R4: burst write across the wrap point
    bus_start;
    send(8'hBA, a); chk("R4", a, 1);
    send(8'h06, a); chk("R4", a, 1);
    send(8'h09, a); chk("R4", a, 1);
    send(8'h0F, a); chk("R4", a, 1);
    send(8'h04, a); chk("R4", a, 1);
    bus_stop;
    chk("R4", cfg_regs, 32'hF900_A004);
    chk("R1", sda_drive_low, 0);

    // R6: burst read with wrap, host NACK ends it
    bus_start;
    send(8'hBA, a); chk("R6", a, 1);
    send(8'h06, a); chk("R6", a, 1);
    bus_start;
    send(8'hBB, a); chk("R6", a, 1);
    recv(1'b0, b);  chk("R6", b, 8'h09);
    recv(1'b0, b);  chk("R6", b, 8'h0F);
    recv(1'b1, b);  chk("R6", b, 8'h04);
    bus_stop;
    chk("R6", sda_drive_low, 0);

    // R9: control write applies only after stop
    bus_start;
    send(8'hBA, a); chk("R9", a, 1);
    send(8'h07, a); chk("R9", a, 1);
    send(8'h07, a); chk("R9", a, 1);
    send(8'h0C, a); chk("R9", a, 1);
    bus_start;
    send(8'hAA, a); chk("R9", a, 0);
    bus_stop;
    chk("R9", cfg_regs, 32'h7900_A00C);

    // R2: type code now 1010
    bus_start;
    send(8'hBA, a); chk("R2", a, 0);
    bus_stop;
    bus_start;
    send(8'hAA, a); chk("R2", a, 1);
    send(8'h00, a); chk("R2", a, 1);
    bus_start;
    send(8'hAB, a); chk("R2", a, 1);
    recv(1'b1, b);  chk("R6", b, 8'h0C);
    bus_stop;

    // R3: exact strap match, then wildcard
    bus_start;
    send(8'hA8, a); chk("R3", a, 0);
    bus_stop;
    wr_word("R3", 8'hAA, 8'h07, 8'h06);
    bus_start;
    send(8'hA8, a); chk("R3", a, 1);
    send(8'h00, a); chk("R3", a, 1);
    bus_start;
    send(8'hA9, a); chk("R3", a, 1);
    recv(1'b1, b);  chk("R3", b, 8'h0C);
    bus_stop;

    // R8: read-only mode
    do_reset;
    chk("R11", cfg_regs, 32'hF000_0000);
    wr_word("R8", 8'hBA, 8'h00, 8'h06);
    wr_word("R8", 8'hBA, 8'h07, 8'h02);
    bus_start;
    send(8'hA0, a); chk("R8", a, 0);
    send(8'h00, a);
    send(8'h0F, a);
    bus_stop;
    chk("R8", cfg_regs, 32'h2000_0006);
    bus_start;
    send(8'hA1, a); chk("R8", a, 1);
    recv(1'b1, b);  chk("R8", b, 8'h06);
    bus_stop;

    // R7: denied mode
    do_reset;
    wr_word("R7", 8'hBA, 8'h07, 8'h09);
    bus_start;
    send(8'hBA, a); chk("R7", a, 0);
    bus_stop;
    bus_start;
    send(8'hBB, a); chk("R7", a, 0);
    bus_stop;
    chk("R7", cfg_regs, 32'h9000_0000);
    chk("R10", sda_drive_low, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule